// File: doc/BRIEF.md
# Precise Exception Dispatcher

This block sits beside the retire end of an in-order-completing core. It decides when an exception is taken and which one is taken. Each cycle it looks at three kinds of request. The first kind cannot be masked: reset and machine check. The second is a fault reported by the oldest in-flight instruction. The third is a set of level-sensitive interrupt lines that software can mask. The block picks at most one winner. For that winner it builds a redirect to a fixed vector, records the resume address in SRR0 and copies the machine-state word into SRR1. It then switches the core to supervisor mode with interrupts, single-step and branch-trace disabled.

Maskable interrupts wait for a safe point. A safe point is either an empty pipeline, where the fetch restart address is saved, or the cycle in which the head instruction retires cleanly, where the following address is saved. Instruction faults are served only at the head, so older work has always finished first. A return-from-interrupt request puts the saved machine state back and redirects to the saved address. The redirect leaves the block as a valid/ready stream. While a redirect is outstanding, every new request is held off, so exceptions are served strictly one at a time.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, `redir_valid`=0, `kill_head`=0, `srr0_q`=0, `srr1_q`=0 and `msr_q`=6'h20. The machine-state bits are: bit0 external enable (EE), bit1 machine-check enable (ME), bit2 single-step (SE), bit3 branch trace (BE), bit4 translation (IR), bit5 supervisor (SUP).
- R2: Vector offsets are added to VEC_BASE, whose low 16 bits are zero.
  - Reset uses 0x100 and machine check uses 0x200.
  - Interrupt line irq[0] uses 0x500, irq[1] 0x900, irq[2] 0xF00, irq[3] 0x1400 and irq[4] 0x1700.
  - Fault cause codes map as follows: 0→0x300, 1→0x400, 2→0x600, 3→0x700, 4 (trap)→0x700, 5→0x800, 6 (syscall)→0xC00, 7 (trace)→0xD00, 8→0x1300. Any other code maps to 0x700.
  - Reserved offsets are never produced.
- R3: When requests meet in one cycle, the order of precedence is reset, then machine check, then the head fault, then the interrupt lines. Among the lines, irq[0] ranks highest and irq[4] lowest.
- R4: An interrupt line is taken only while EE=1. While EE=0 it is held and not lost.
- R5: Machine check is taken only while ME=1. Reset is taken whatever the machine state.
- R6: An interrupt is taken in only two cases. When `cq_empty`=1, SRR0 gets `restart_pc`. When the head retires (`cq_valid`&`cq_done`) with no accepted fault, SRR0 gets `cq_next_pc` and `kill_head` stays 0. In any other case the interrupt waits.
- R7: A head fault (`cq_valid`&`cq_fault`) is taken with `kill_head`=1 in the same cycle. SRR0 gets `cq_pc`, except for codes 4, 6 and 7, where SRR0 gets `cq_next_pc`.
- R8: A trace cause (code 7) is accepted only when SE or BE is 1. Otherwise the head is treated as fault-free.
- R9: When an exception is taken:
  - SRR1 gets the old machine state.
  - EE, SE and BE are cleared and SUP is set.
  - ME and IR keep their values.
  - All of these changes are visible in the cycle where `redir_valid` rises.
- R10: `redir_valid` rises on the edge after acceptance, with `redir_exc`=1 for an exception and 0 for a return. It stays high with a stable address until `redir_ready`=1. While it is high, no exception, return or state write is accepted.
- R11: A return (`rfi_req`) is accepted when no redirect is outstanding and no exception is taken. It loads the machine state from SRR1 and redirects to SRR0.
- R12: `msr_we` loads `msr_wdata` when nothing else is accepted in that cycle.
- R13: For reset and machine check, SRR0 gets `cq_pc` and `kill_head`=1 when `cq_valid`=1. Otherwise SRR0 gets `restart_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cq_empty | input | 1 | No instruction in flight |
| cq_valid | input | 1 | Head of the completion queue is valid |
| cq_done | input | 1 | Head retires this cycle |
| cq_fault | input | 1 | Head raised a fault |
| cq_cause | input | 4 | Fault cause code of the head |
| cq_pc | input | ADDR_W | Address of the head instruction |
| cq_next_pc | input | ADDR_W | Address following the head |
| restart_pc | input | ADDR_W | Fetch restart address when the pipeline is empty |
| rst_src | input | N_RST | Hard, soft and power-on reset requests |
| mchk_src | input | N_MCHK | Bus error, check pin and parity error requests |
| irq | input | 5 | Maskable interrupt lines |
| msr_we | input | 1 | Write enable for the machine state |
| msr_wdata | input | 6 | Machine-state write data |
| rfi_req | input | 1 | Return-from-interrupt request |
| redir_ready | input | 1 | Consumer accepts the redirect |
| redir_valid | output | 1 | Redirect is pending |
| redir_addr | output | ADDR_W | Redirect target |
| redir_exc | output | 1 | 1 = exception entry, 0 = return |
| kill_head | output | 1 | Head must not complete (combinational) |
| msr_q | output | 6 | Current machine state |
| srr0_q | output | ADDR_W | Saved resume address |
| srr1_q | output | 6 | Saved machine state |

## Verification
A wrong precedence or masking state shows up as a wrong `redir_addr` or SRR0 value on the first redirect after the colliding requests. It can also show up as a redirect that appears while EE or ME is clear, or that never appears. A corrupted save or restore path shows up one cycle after acceptance, as a machine-state or SRR1 value that differs from the state computed before the event. A broken hold under back-pressure shows up as a changed address, or a second dispatch, while `redir_ready` is low.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int MSR_W = 6;
  localparam int EE  = 0;
  localparam int ME  = 1;
  localparam int SE  = 2;
  localparam int BE  = 3;
  localparam int IR  = 4;
  localparam int SUP = 5;
  localparam int NIRQ  = 5;
  localparam int OFS_W = 16;
  localparam int CAUSE_W = 4;

  localparam logic [MSR_W-1:0] MSR_RST = 6'h20;
  localparam logic [OFS_W-1:0] OFS_RESET = 16'h0100;
  localparam logic [OFS_W-1:0] OFS_MCHK  = 16'h0200;

  localparam logic [CAUSE_W-1:0] CZ_DSTORE  = 4'd0;
  localparam logic [CAUSE_W-1:0] CZ_ISTORE  = 4'd1;
  localparam logic [CAUSE_W-1:0] CZ_ALIGN   = 4'd2;
  localparam logic [CAUSE_W-1:0] CZ_PROG    = 4'd3;
  localparam logic [CAUSE_W-1:0] CZ_TRAP    = 4'd4;
  localparam logic [CAUSE_W-1:0] CZ_FPU     = 4'd5;
  localparam logic [CAUSE_W-1:0] CZ_SYSCALL = 4'd6;
  localparam logic [CAUSE_W-1:0] CZ_TRACE   = 4'd7;
  localparam logic [CAUSE_W-1:0] CZ_IBRK    = 4'd8;

  typedef enum logic [1:0] {SEL_HEAD, SEL_NEXT, SEL_RESTART} pc_sel_e;

  // Offset for maskable line idx; lower index = higher precedence.
  function automatic logic [OFS_W-1:0] irq_offset(int idx);
    case (idx)
      0:       return 16'h0500;
      1:       return 16'h0900;
      2:       return 16'h0F00;
      3:       return 16'h1400;
      default: return 16'h1700;
    endcase
  endfunction

  function automatic logic [MSR_W-1:0] enter_sup(logic [MSR_W-1:0] m);
    logic [MSR_W-1:0] r;
    r = m;
    r[EE]  = 1'b0;
    r[SE]  = 1'b0;
    r[BE]  = 1'b0;
    r[SUP] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/exc_cause_map.sv
module exc_cause_map
  import exc_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  output logic [OFS_W-1:0]   ofs,
  output logic               resume_next,
  output logic               is_trace
);
  always_comb begin
    resume_next = 1'b0;
    is_trace    = 1'b0;
    case (cause)
      CZ_DSTORE:  ofs = 16'h0300;
      CZ_ISTORE:  ofs = 16'h0400;
      CZ_ALIGN:   ofs = 16'h0600;
      CZ_PROG:    ofs = 16'h0700;
      CZ_TRAP: begin
        ofs = 16'h0700;
        resume_next = 1'b1;
      end
      CZ_FPU:     ofs = 16'h0800;
      CZ_SYSCALL: begin
        ofs = 16'h0C00;
        resume_next = 1'b1;
      end
      CZ_TRACE: begin
        ofs = 16'h0D00;
        resume_next = 1'b1;
        is_trace = 1'b1;
      end
      CZ_IBRK:    ofs = 16'h1300;
      default:    ofs = 16'h0700;  // unknown codes fold into program
    endcase
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N_RST  = 3,
  parameter int N_MCHK = 3
) (
  input  logic [N_RST-1:0]  rst_src,
  input  logic [N_MCHK-1:0] mchk_src,
  input  logic [NIRQ-1:0]   irq,
  input  logic [MSR_W-1:0]  msr,
  input  logic              busy,
  input  logic              cq_empty,
  input  logic              cq_valid,
  input  logic              cq_done,
  input  logic              cq_fault,
  input  logic [OFS_W-1:0]  fault_ofs,
  input  logic              fault_next,
  input  logic              fault_trace,
  output logic              take,
  output logic [OFS_W-1:0]  ofs,
  output pc_sel_e           pc_sel,
  output logic              kill
);
  logic [NIRQ-1:0]  irq_ok;
  logic [OFS_W-1:0] async_ofs;
  logic rst_hit, mc_hit, fault_hit, safe_point, async_hit;

  generate
    for (genvar i = 0; i < NIRQ; i++) begin : g_mask
      assign irq_ok[i] = irq[i] & msr[EE];
    end
  endgenerate

  // Lowest set index wins: scan from the top so the last hit kept is the lowest.
  always_comb begin
    async_ofs = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (irq_ok[i]) async_ofs = irq_offset(i);
    end
  end

  assign rst_hit    = |rst_src;
  assign mc_hit     = (|mchk_src) & msr[ME];
  assign fault_hit  = cq_valid & cq_fault & (~fault_trace | msr[SE] | msr[BE]);
  assign safe_point = cq_empty | (cq_valid & cq_done & ~fault_hit);
  assign async_hit  = (|irq_ok) & safe_point;

  always_comb begin
    take   = 1'b0;
    ofs    = '0;
    pc_sel = SEL_RESTART;
    kill   = 1'b0;
    if (!busy) begin
      if (rst_hit || mc_hit) begin
        take   = 1'b1;
        ofs    = rst_hit ? OFS_RESET : OFS_MCHK;
        pc_sel = cq_valid ? SEL_HEAD : SEL_RESTART;
        kill   = cq_valid;
      end else if (fault_hit) begin
        take   = 1'b1;
        ofs    = fault_ofs;
        pc_sel = fault_next ? SEL_NEXT : SEL_HEAD;
        kill   = 1'b1;
      end else if (async_hit) begin
        take   = 1'b1;
        ofs    = async_ofs;
        pc_sel = cq_empty ? SEL_RESTART : SEL_NEXT;
      end
    end
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [OFS_W-1:0]  ofs,
  input  pc_sel_e           pc_sel,
  input  logic [ADDR_W-1:0] cq_pc,
  input  logic [ADDR_W-1:0] cq_next_pc,
  input  logic [ADDR_W-1:0] restart_pc,
  input  logic              rfi_req,
  input  logic              msr_we,
  input  logic [MSR_W-1:0]  msr_wdata,
  input  logic              redir_ready,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_addr,
  output logic              redir_exc,
  output logic [MSR_W-1:0]  msr_q,
  output logic [ADDR_W-1:0] srr0_q,
  output logic [MSR_W-1:0]  srr1_q
);
  logic [ADDR_W-1:0] save_pc;

  always_comb begin
    case (pc_sel)
      SEL_HEAD: save_pc = cq_pc;
      SEL_NEXT: save_pc = cq_next_pc;
      default:  save_pc = restart_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
      redir_exc   <= 1'b0;
      msr_q       <= MSR_RST;
      srr0_q      <= '0;
      srr1_q      <= '0;
    end else if (redir_valid) begin
      if (redir_ready) redir_valid <= 1'b0;
    end else if (take) begin
      redir_valid <= 1'b1;
      redir_exc   <= 1'b1;
      redir_addr  <= VEC_BASE | ADDR_W'(ofs);
      srr0_q      <= save_pc;
      srr1_q      <= msr_q;
      msr_q       <= enter_sup(msr_q);
    end else if (rfi_req) begin
      redir_valid <= 1'b1;
      redir_exc   <= 1'b0;
      redir_addr  <= srr0_q;
      msr_q       <= srr1_q;
    end else if (msr_we) begin
      msr_q <= msr_wdata;
    end
  end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0,
  parameter int                N_RST    = 3,
  parameter int                N_MCHK   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cq_empty,
  input  logic                cq_valid,
  input  logic                cq_done,
  input  logic                cq_fault,
  input  logic [CAUSE_W-1:0]  cq_cause,
  input  logic [ADDR_W-1:0]   cq_pc,
  input  logic [ADDR_W-1:0]   cq_next_pc,
  input  logic [ADDR_W-1:0]   restart_pc,
  input  logic [N_RST-1:0]    rst_src,
  input  logic [N_MCHK-1:0]   mchk_src,
  input  logic [NIRQ-1:0]     irq,
  input  logic                msr_we,
  input  logic [MSR_W-1:0]    msr_wdata,
  input  logic                rfi_req,
  input  logic                redir_ready,
  output logic                redir_valid,
  output logic [ADDR_W-1:0]   redir_addr,
  output logic                redir_exc,
  output logic                kill_head,
  output logic [MSR_W-1:0]    msr_q,
  output logic [ADDR_W-1:0]   srr0_q,
  output logic [MSR_W-1:0]    srr1_q
);
  logic [OFS_W-1:0] fault_ofs, win_ofs;
  logic             fault_next, fault_trace, take;
  pc_sel_e          pc_sel;

  exc_cause_map u_map (
    .cause       (cq_cause),
    .ofs         (fault_ofs),
    .resume_next (fault_next),
    .is_trace    (fault_trace)
  );

  exc_arbiter #(.N_RST(N_RST), .N_MCHK(N_MCHK)) u_arb (
    .rst_src     (rst_src),
    .mchk_src    (mchk_src),
    .irq         (irq),
    .msr         (msr_q),
    .busy        (redir_valid),
    .cq_empty    (cq_empty),
    .cq_valid    (cq_valid),
    .cq_done     (cq_done),
    .cq_fault    (cq_fault),
    .fault_ofs   (fault_ofs),
    .fault_next  (fault_next),
    .fault_trace (fault_trace),
    .take        (take),
    .ofs         (win_ofs),
    .pc_sel      (pc_sel),
    .kill        (kill_head)
  );

  exc_state #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .ofs         (win_ofs),
    .pc_sel      (pc_sel),
    .cq_pc       (cq_pc),
    .cq_next_pc  (cq_next_pc),
    .restart_pc  (restart_pc),
    .rfi_req     (rfi_req),
    .msr_we      (msr_we),
    .msr_wdata   (msr_wdata),
    .redir_ready (redir_ready),
    .redir_valid (redir_valid),
    .redir_addr  (redir_addr),
    .redir_exc   (redir_exc),
    .msr_q       (msr_q),
    .srr0_q      (srr0_q),
    .srr1_q      (srr1_q)
  );
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              redir_valid,
  input logic              redir_ready,
  input logic [ADDR_W-1:0] redir_addr,
  input logic              redir_exc,
  input logic              kill_head,
  input logic [MSR_W-1:0]  msr_q,
  input logic [ADDR_W-1:0] srr0_q,
  input logic [MSR_W-1:0]  srr1_q
);
  function automatic logic legal_ofs(logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] o;
    o = a - VEC_BASE;
    if (o[7:0] != 8'h00 || (o >> 16) != '0) return 1'b0;
    return o[15:8] inside {8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                           8'h08, 8'h09, 8'h0C, 8'h0D, 8'h0F, 8'h13, 8'h14, 8'h17};
  endfunction

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && !redir_ready |=> redir_valid && $stable(redir_addr) && $stable(redir_exc));

  assert_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !kill_head);

  assert_legal_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid && redir_exc |-> legal_ofs(redir_addr));

  assert_kill_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_head |=> redir_valid && redir_exc);

  assert_save_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_valid) && redir_exc |-> srr1_q == $past(msr_q) && !msr_q[EE]
      && !msr_q[SE] && !msr_q[BE] && msr_q[SUP] && msr_q[ME] == $past(msr_q[ME]));

  assert_return_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redir_valid) && !redir_exc |-> msr_q == $past(srr1_q) && redir_addr == $past(srr0_q));
endmodule

bind exc_dispatch exc_dispatch_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .redir_valid (redir_valid),
  .redir_ready (redir_ready),
  .redir_addr  (redir_addr),
  .redir_exc   (redir_exc),
  .kill_head   (kill_head),
  .msr_q       (msr_q),
  .srr0_q      (srr0_q),
  .srr1_q      (srr1_q)
);

// File: tb/exc_dispatch_bench.sv
module exc_dispatch_bench;
  localparam int CLK_NS = 20;  // 50 MHz
  localparam logic [31:0] RESTART = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cq_empty, cq_valid, cq_done, cq_fault;
  logic [3:0]  cq_cause;
  logic [31:0] cq_pc, cq_next_pc, restart_pc;
  logic [2:0]  rst_src, mchk_src;
  logic [4:0]  irq;
  logic        msr_we, rfi_req, redir_ready;
  logic [5:0]  msr_wdata;
  logic        redir_valid, redir_exc, kill_head;
  logic [31:0] redir_addr, srr0_q;
  logic [5:0]  msr_q, srr1_q;

  always #(CLK_NS / 2) clk = ~clk;

  exc_dispatch u_exc_dispatch (
    .clk(clk), .rst_n(rst_n), .cq_empty(cq_empty), .cq_valid(cq_valid),
    .cq_done(cq_done), .cq_fault(cq_fault), .cq_cause(cq_cause), .cq_pc(cq_pc),
    .cq_next_pc(cq_next_pc), .restart_pc(restart_pc), .rst_src(rst_src),
    .mchk_src(mchk_src), .irq(irq), .msr_we(msr_we), .msr_wdata(msr_wdata),
    .rfi_req(rfi_req), .redir_ready(redir_ready), .redir_valid(redir_valid),
    .redir_addr(redir_addr), .redir_exc(redir_exc), .kill_head(kill_head),
    .msr_q(msr_q), .srr0_q(srr0_q), .srr1_q(srr1_q)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] srr0;
    logic [5:0]  srr1;
    logic [5:0]  msr;
    logic        exc;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int n_chk = 0;
  int n_err = 0;
  logic [5:0]  msr_m, srr1_m;
  logic [31:0] srr0_m;

  function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endfunction

  // Vector table written from the requirement text (R2).
  function automatic logic [31:0] vec_of(int c);
    case (c)
      0: return 32'h300;  1: return 32'h400;  2: return 32'h600;
      3: return 32'h700;  4: return 32'h700;  5: return 32'h800;
      6: return 32'hC00;  7: return 32'hD00;  8: return 32'h1300;
      default: return 32'h700;
    endcase
  endfunction

  function automatic logic after_type(int c);
    return (c == 4) || (c == 6) || (c == 7);
  endfunction

  // Monitor: pop and compare on every handshake.
  always @(negedge clk) begin
    if (rst_n && redir_valid && redir_ready) begin
      if (sbq.size() == 0) begin
        chk("R10", "unexpected redirect", redir_addr, 32'hFFFF_FFFF);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(e.tag, "redir_addr", redir_addr, e.addr);
        chk(e.tag, "redir_exc", {31'd0, redir_exc}, {31'd0, e.exc});
        chk(e.exc ? "R9" : "R11", "srr1", {26'd0, srr1_q}, {26'd0, e.srr1});
        chk(e.exc ? "R9" : "R11", "msr", {26'd0, msr_q}, {26'd0, e.msr});
        chk(e.tag, "srr0", srr0_q, e.srr0);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #3;
  endtask

  task automatic wait_idle();
    while (redir_valid) cyc();
  endtask

  task automatic exp_take(string tag, logic [31:0] addr, logic [31:0] s0);
    exp_t e;
    logic [5:0] nm;
    nm = (msr_m & ~6'h0D) | 6'h20;
    e.addr = addr; e.srr0 = s0; e.srr1 = msr_m; e.msr = nm; e.exc = 1'b1; e.tag = tag;
    sbq.push_back(e);
    srr1_m = msr_m; srr0_m = s0; msr_m = nm;
  endtask

  task automatic do_rfi();
    exp_t e;
    wait_idle();
    e.addr = srr0_m; e.srr0 = srr0_m; e.srr1 = srr1_m; e.msr = srr1_m; e.exc = 1'b0;
    e.tag = "R11";
    sbq.push_back(e);
    msr_m = srr1_m;
    rfi_req = 1'b1;
    cyc();
    rfi_req = 1'b0;
    cyc();
  endtask

  task automatic wr_msr(logic [5:0] v);
    wait_idle();
    msr_we = 1'b1; msr_wdata = v;
    cyc();
    msr_we = 1'b0;
    msr_m = v;
  endtask

  task automatic clear_cq();
    cq_valid = 1'b0; cq_done = 1'b0; cq_fault = 1'b0; cq_cause = '0; cq_empty = 1'b1;
  endtask

  task automatic set_head(logic [31:0] pc, logic done, logic flt, logic [3:0] c);
    cq_empty = 1'b0; cq_valid = 1'b1; cq_done = done; cq_fault = flt; cq_cause = c;
    cq_pc = pc; cq_next_pc = pc + 32'd4;
  endtask

  task automatic run_fault(int c, logic [31:0] pc);
    wait_idle();
    exp_take("R2 R7", vec_of(c), after_type(c) ? pc + 32'd4 : pc);
    set_head(pc, 1'b1, 1'b1, 4'(c));
    #1 chk("R7", "kill_head on fault", {31'd0, kill_head}, 32'd1);
    cyc();
    clear_cq();
    cyc();
    do_rfi();
  endtask

  // Watchdog.
  initial begin
    #(CLK_NS * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int causes[9];
    causes = '{0, 1, 2, 3, 4, 5, 6, 8, 15};
    rst_n = 1'b0; clear_cq(); cq_pc = '0; cq_next_pc = '0; restart_pc = RESTART;
    rst_src = '0; mchk_src = '0; irq = '0; msr_we = 1'b0; msr_wdata = '0;
    rfi_req = 1'b0; redir_ready = 1'b1;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk("R1", "redir_valid", {31'd0, redir_valid}, 32'd0);
    chk("R1", "kill_head", {31'd0, kill_head}, 32'd0);
    chk("R1", "msr", {26'd0, msr_q}, 32'h20);
    chk("R1", "srr0", srr0_q, 32'd0);
    chk("R1", "srr1", {26'd0, srr1_q}, 32'd0);
    msr_m = 6'h20; srr0_m = '0; srr1_m = '0;

    // R12 state write
    wr_msr(6'h03);
    chk("R12", "msr after write", {26'd0, msr_q}, 32'h03);

    // R2 / R7: every cause code
    foreach (causes[i]) run_fault(causes[i], 32'h1000 + 32'(i) * 32'h100);

    // R4: masked interrupt held, then taken once enabled
    wr_msr(6'h02);
    irq = 5'b00001;
    repeat (3) cyc();
    chk("R4", "no redirect while EE=0", {31'd0, redir_valid}, 32'd0);
    chk("R4", "msr unchanged", {26'd0, msr_q}, 32'h02);
    wr_msr(6'h03);
    exp_take("R4", 32'h500, RESTART);
    cyc();
    irq = '0;
    cyc();
    do_rfi();

    // R6: deferral until the head retires
    set_head(32'h5000, 1'b0, 1'b0, 4'd0);
    irq = 5'b00010;
    repeat (3) cyc();
    chk("R6", "held while head busy", {31'd0, redir_valid}, 32'd0);
    exp_take("R6", 32'h900, 32'h5004);
    cq_done = 1'b1;
    #1 chk("R6", "head completes", {31'd0, kill_head}, 32'd0);
    cyc();
    clear_cq(); irq = '0;
    cyc();
    do_rfi();

    // R3: head fault beats an interrupt at retire
    irq = 5'b00001;
    exp_take("R3", 32'h600, 32'h6000);
    set_head(32'h6000, 1'b1, 1'b1, 4'd2);
    cyc();
    irq = '0; clear_cq();
    cyc();
    do_rfi();

    // R3: interrupt line order
    exp_take("R3", 32'h900, RESTART);
    irq = 5'b11010;
    cyc();
    irq = 5'b11000;
    cyc();
    do_rfi();
    exp_take("R3", 32'h1400, RESTART);
    cyc();
    irq = 5'b10000;
    cyc();
    do_rfi();
    exp_take("R3", 32'h1700, RESTART);
    cyc();
    irq = '0;
    cyc();
    do_rfi();
    exp_take("R2", 32'hF00, RESTART);
    irq = 5'b00100;
    cyc();
    irq = '0;
    cyc();
    do_rfi();

    // R5: machine check gated by ME
    wr_msr(6'h01);
    mchk_src = 3'b001;
    repeat (3) cyc();
    chk("R5", "no machine check while ME=0", {31'd0, redir_valid}, 32'd0);
    wr_msr(6'h03);
    exp_take("R5", 32'h200, RESTART);
    cyc();
    mchk_src = '0;
    cyc();
    do_rfi();

    // R13 / R3: machine check over a head fault
    wait_idle();
    exp_take("R13", 32'h200, 32'h7000);
    mchk_src = 3'b010;
    set_head(32'h7000, 1'b1, 1'b1, 4'd0);
    #1 chk("R13", "kill_head on machine check", {31'd0, kill_head}, 32'd1);
    cyc();
    mchk_src = '0; clear_cq();
    cyc();
    do_rfi();

    // R5 / R3: reset wins over everything, even with ME=0
    wr_msr(6'h00);
    exp_take("R5", 32'h100, 32'h7100);
    rst_src = 3'b010; mchk_src = 3'b001; irq = 5'b11111;
    set_head(32'h7100, 1'b1, 1'b1, 4'd6);
    cyc();
    rst_src = '0; mchk_src = '0; irq = '0; clear_cq();
    cyc();
    do_rfi();
    chk("R11", "msr restored", {26'd0, msr_q}, 32'h00);

    // R8: trace gated by SE/BE
    wr_msr(6'h03);
    set_head(32'h7200, 1'b1, 1'b1, 4'd7);
    #1 chk("R8", "no kill for masked trace", {31'd0, kill_head}, 32'd0);
    repeat (3) cyc();
    chk("R8", "no trace redirect", {31'd0, redir_valid}, 32'd0);
    wr_msr(6'h07);
    exp_take("R8", 32'hD00, 32'h7204);
    cyc();
    clear_cq();
    cyc();
    do_rfi();
    wr_msr(6'h03);

    // R10: back-pressure holds the redirect and blocks new requests
    wait_idle();
    redir_ready = 1'b0;
    exp_take("R10", 32'h400, 32'h8000);
    set_head(32'h8000, 1'b1, 1'b1, 4'd1);
    cyc();
    clear_cq();
    rst_src = 3'b001;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk("R10", "valid held", {31'd0, redir_valid}, 32'd1);
      chk("R10", "addr held", redir_addr, 32'h400);
    end
    exp_take("R10", 32'h100, RESTART);
    redir_ready = 1'b1;
    cyc();
    cyc();
    rst_src = '0;
    cyc();
    do_rfi();

    repeat (4) cyc();
    chk("R10", "scoreboard drained", 32'(sbq.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule